// File: doc/BRIEF.md
# PC Card Memory Window Mapper

This block translates host memory addresses into card memory addresses for one socket of a PC card controller. It holds a set of programmable memory windows. Each window describes a range of 4 KB host pages, given as a first page and an inclusive last page. It also holds a 14-bit page offset that moves the range into the card's address space, along with per-window access attributes: bus width, wait states, attribute-space selection and write protection.

Software programs the windows one byte at a time through an indexed register port. Every 16-bit window field occupies two consecutive byte registers, and a shared enable register switches each window on or off. On the host side the block looks at a 24-bit address and, in the same cycle, reports whether an enabled window covers it. For a covered address it also reports which window matched, the translated card address and the access controls to use. A host write that lands in a protected window never becomes a card write.

Top module: `pcmw_mapper`

## Requirements
- R1: With window w enabled, `win_hit` is 1 exactly when the page host_addr[23:12] satisfies start page <= page <= stop page. Both bounds are inclusive, so a window whose stop page is below its start page never hits.
- R2: Bit w of the enable register (index 0x06) enables window w. A window whose bit is clear never hits. Reset clears every enable bit and every window byte. The enable register reads back the stored bits in [4:0] and zero in [7:5].
- R3: On a hit, card_addr[25:12] = (host page + window offset) mod 2^14 and card_addr[11:0] = host_addr[11:0].
- R4: The registers of window w start at index 0x10 + 8*w. In order they are: start low, start high, stop low, stop high, offset low, offset high (+0 .. +5). Page bits [11:8] sit in bits [3:0] of the start-high and stop-high bytes. Offset bits [13:8] sit in bits [5:0] of the offset-high byte.
- R5: On a hit, `card_wide16` is bit 7 of the start-high byte, `card_zero_ws` is bit 6 of the start-high byte, and `card_ws` is bits [7:6] of the stop-high byte.
- R6: On a hit, `card_attr` is bit 6 of the offset-high byte. Bit 7 of that byte is write protect. `card_we` = `host_wr` AND hit AND NOT write-protect.
- R7: When several enabled windows cover the same page, the lowest-numbered one drives every card output, and `win_idx` gives its number.
- R8: A register write takes effect at the next clock edge. The host decode uses the register contents from before that edge. `cfg_rdata` combinationally returns the stored byte at `cfg_idx`.
- R9: Indices outside the enable register and the six bytes of each window read as 0, and writes to them change nothing.
- R10: Without a hit, `card_addr`, `win_idx`, `card_we` and all control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data at `cfg_idx` |
| host_addr | input | 24 | Host memory address |
| host_wr | input | 1 | Host access is a write |
| win_hit | output | 1 | An enabled window covers `host_addr` |
| win_idx | output | 3 | Number of the selected window |
| card_addr | output | 26 | Translated card address |
| card_we | output | 1 | Write permitted to reach the card |
| card_wide16 | output | 1 | 16-bit data width for this access |
| card_zero_ws | output | 1 | Zero-wait-state access |
| card_ws | output | 2 | Wait-state select |
| card_attr | output | 1 | Access targets attribute memory |

## Verification
A register write and a host decode can fall in the same cycle. In that case the decode must still see the old contents, and it must change only after the clock edge. The bench provokes this by holding a host address inside or just outside a window while it rewrites that window's bounds, offset or enable bit in the same cycle. A behavioural model that commits writes only at the edge then predicts every output at each falling edge. Overlapping windows that are enabled and disabled under a steady address stress the priority choice in the same way.

// File: rtl/pcmw_pkg.sv
package pcmw_pkg;

   // Raw 16-bit window fields as software wrote them
   typedef struct packed {
      logic [15:0] start;
      logic [15:0] stop;
      logic [15:0] ofs;
   } win_raw_t;

   // Flag positions within the 16-bit fields (high-byte bits 7 and 6)
   localparam int unsigned FLAG_HI = 15;
   localparam int unsigned FLAG_LO = 14;

   // Byte slots inside one window's register group
   localparam int unsigned SLOT_COUNT = 6;
   localparam int unsigned SLOT_STRIDE = 8;

endpackage

// File: rtl/pcmw_regfile.sv
module pcmw_regfile
   import pcmw_pkg::*;
#(
   parameter int unsigned NUM_WIN  = 5,
   parameter int unsigned IDX_W    = 8,
   parameter int unsigned REG_BASE = 16,
   parameter int unsigned ENA_IDX  = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [IDX_W-1:0]               idx,
   input  logic [7:0]                     wdata,
   output logic [7:0]                     rdata,
   output logic [NUM_WIN-1:0]             ena_o,
   output win_raw_t [NUM_WIN-1:0]         raw_o
);

   localparam int unsigned NPARTS = NUM_WIN * SLOT_COUNT;

   logic [NUM_WIN-1:0] ena_q;
   logic [7:0]         rd_part [NPARTS];
   logic               slot_sel [NPARTS];
   logic               mapped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ena_q <= '0;
      else if (we && idx == IDX_W'(ENA_IDX))
         ena_q <= wdata[NUM_WIN-1:0];
   end
   assign ena_o = ena_q;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam int unsigned WB = REG_BASE + SLOT_STRIDE * w;
      logic [7:0] wbytes [SLOT_COUNT];
      for (genvar k = 0; k < SLOT_COUNT; k++) begin : g_slot
         logic [7:0] b_q;
         logic       sel;
         assign sel = (idx == IDX_W'(WB + k));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               b_q <= 8'h00;
            else if (we && sel)
               b_q <= wdata;
         end
         assign wbytes[k]                    = b_q;
         assign rd_part[w*SLOT_COUNT + k]    = sel ? b_q : 8'h00;
         assign slot_sel[w*SLOT_COUNT + k]   = sel;
      end
      assign raw_o[w].start = {wbytes[1], wbytes[0]};
      assign raw_o[w].stop  = {wbytes[3], wbytes[2]};
      assign raw_o[w].ofs   = {wbytes[5], wbytes[4]};
   end

   always_comb begin
      rdata  = (idx == IDX_W'(ENA_IDX)) ? 8'(ena_q) : 8'h00;
      mapped = (idx == IDX_W'(ENA_IDX));
      for (int i = 0; i < NPARTS; i++) begin
         rdata  = rdata | rd_part[i];
         mapped = mapped | slot_sel[i];
      end
   end

   // R2 / R8: enable write lands exactly one edge later
   p_ena_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == IDX_W'(ENA_IDX)) |=> (ena_o == $past(wdata[NUM_WIN-1:0])));

   // R9: writes to unmapped indices leave all storage untouched
   p_unmapped_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !mapped) |=> ($stable(raw_o) && $stable(ena_o)));

endmodule

// File: rtl/pcmw_win_match.sv
module pcmw_win_match
   import pcmw_pkg::*;
#(
   parameter int unsigned PAGE_W = 12
) (
   input  logic [PAGE_W-1:0] page,
   input  win_raw_t          raw,
   input  logic              en,
   output logic              hit
);

   logic [PAGE_W-1:0] first_pg;
   logic [PAGE_W-1:0] last_pg;

   assign first_pg = raw.start[PAGE_W-1:0];
   assign last_pg  = raw.stop[PAGE_W-1:0];
   assign hit      = en && (page >= first_pg) && (page <= last_pg);

endmodule

// File: rtl/pcmw_prio.sv
module pcmw_prio #(
   parameter int unsigned N  = 5,
   parameter int unsigned IW = 3
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);

   assign any = |req;

   if (N == 1) begin : g_single
      assign grant = req;
      assign idx   = '0;
   end else begin : g_multi
      always_comb begin
         grant = '0;
         idx   = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
               grant    = '0;
               grant[i] = 1'b1;
               idx      = IW'(i);
            end
         end
      end
   end

endmodule

// File: rtl/pcmw_xlate.sv
module pcmw_xlate
   import pcmw_pkg::*;
#(
   parameter int unsigned NUM_WIN    = 5,
   parameter int unsigned HADDR_W    = 24,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned OFS_W      = 14
) (
   input  logic [NUM_WIN-1:0]          grant,
   input  logic                        any,
   input  win_raw_t [NUM_WIN-1:0]      raw,
   input  logic [HADDR_W-1:0]          host_addr,
   input  logic                        host_wr,
   output logic [OFS_W+PAGE_SHIFT-1:0] card_addr,
   output logic                        card_we,
   output logic                        card_wide16,
   output logic                        card_zero_ws,
   output logic [1:0]                  card_ws,
   output logic                        card_attr
);

   localparam int unsigned PAGE_W = HADDR_W - PAGE_SHIFT;

   win_raw_t         pick;
   logic [OFS_W-1:0] card_pg;

   always_comb begin
      pick = '0;
      for (int w = 0; w < NUM_WIN; w++)
         if (grant[w]) pick = pick | raw[w];
   end

   assign card_pg = OFS_W'(host_addr[HADDR_W-1:PAGE_SHIFT]) + pick.ofs[OFS_W-1:0];

   always_comb begin
      card_addr    = '0;
      card_we      = 1'b0;
      card_wide16  = 1'b0;
      card_zero_ws = 1'b0;
      card_ws      = 2'b00;
      card_attr    = 1'b0;
      if (any) begin
         card_addr    = {card_pg, host_addr[PAGE_SHIFT-1:0]};
         card_we      = host_wr && !pick.ofs[FLAG_HI];
         card_wide16  = pick.start[FLAG_HI];
         card_zero_ws = pick.start[FLAG_LO];
         card_ws      = pick.stop[FLAG_HI:FLAG_LO];
         card_attr    = pick.ofs[FLAG_LO];
      end
   end

   initial begin
      assert (PAGE_W <= OFS_W) else $error("host page wider than offset field");
   end

endmodule

// File: rtl/pcmw_mapper.sv
module pcmw_mapper
   import pcmw_pkg::*;
#(
   parameter int unsigned NUM_WIN    = 5,
   parameter int unsigned HADDR_W    = 24,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned OFS_W      = 14,
   parameter int unsigned IDX_W      = 8,
   parameter int unsigned REG_BASE   = 16,
   parameter int unsigned ENA_IDX    = 6,
   parameter int unsigned WIN_IW     = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [IDX_W-1:0]            cfg_idx,
   input  logic [7:0]                  cfg_wdata,
   output logic [7:0]                  cfg_rdata,
   input  logic [HADDR_W-1:0]          host_addr,
   input  logic                        host_wr,
   output logic                        win_hit,
   output logic [WIN_IW-1:0]           win_idx,
   output logic [OFS_W+PAGE_SHIFT-1:0] card_addr,
   output logic                        card_we,
   output logic                        card_wide16,
   output logic                        card_zero_ws,
   output logic [1:0]                  card_ws,
   output logic                        card_attr
);

   localparam int unsigned PAGE_W = HADDR_W - PAGE_SHIFT;

   initial begin
      assert (NUM_WIN >= 1 && NUM_WIN <= 8) else $error("NUM_WIN must be 1..8");
      assert ((1 << WIN_IW) >= NUM_WIN) else $error("WIN_IW too narrow");
      assert (PAGE_W <= 14) else $error("page field exceeds 14 bits");
      assert (OFS_W <= 14) else $error("offset field exceeds 14 bits");
      assert (REG_BASE + SLOT_STRIDE * NUM_WIN <= (1 << IDX_W))
         else $error("window registers exceed index space");
      assert (ENA_IDX < REG_BASE || ENA_IDX >= REG_BASE + SLOT_STRIDE * NUM_WIN)
         else $error("enable index overlaps window registers");
   end

   logic [NUM_WIN-1:0]     ena;
   win_raw_t [NUM_WIN-1:0] raw;
   logic [NUM_WIN-1:0]     match;
   logic [NUM_WIN-1:0]     grant;
   logic [WIN_IW-1:0]      gidx;
   logic                   any;

   pcmw_regfile #(
      .NUM_WIN (NUM_WIN),
      .IDX_W   (IDX_W),
      .REG_BASE(REG_BASE),
      .ENA_IDX (ENA_IDX)
   ) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (cfg_we),
      .idx  (cfg_idx),
      .wdata(cfg_wdata),
      .rdata(cfg_rdata),
      .ena_o(ena),
      .raw_o(raw)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      pcmw_win_match #(.PAGE_W(PAGE_W)) u_cmp (
         .page(host_addr[HADDR_W-1:PAGE_SHIFT]),
         .raw (raw[w]),
         .en  (ena[w]),
         .hit (match[w])
      );
      // R2: a disabled window never reports a match
      p_hit_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
         match[w] |-> ena[w]);
   end

   pcmw_prio #(.N(NUM_WIN), .IW(WIN_IW)) u_prio (
      .req  (match),
      .grant(grant),
      .idx  (gidx),
      .any  (any)
   );

   // R7: at most one window is selected
   p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   pcmw_xlate #(
      .NUM_WIN   (NUM_WIN),
      .HADDR_W   (HADDR_W),
      .PAGE_SHIFT(PAGE_SHIFT),
      .OFS_W     (OFS_W)
   ) u_xl (
      .grant       (grant),
      .any         (any),
      .raw         (raw),
      .host_addr   (host_addr),
      .host_wr     (host_wr),
      .card_addr   (card_addr),
      .card_we     (card_we),
      .card_wide16 (card_wide16),
      .card_zero_ws(card_zero_ws),
      .card_ws     (card_ws),
      .card_attr   (card_attr)
   );

   assign win_hit = any;
   assign win_idx = gidx;

   // R6: a card write needs a host write that hits a window
   p_we_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      card_we |-> (host_wr && win_hit));

   // R3: in-page offset passes through untranslated
   p_page_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit |-> (card_addr[PAGE_SHIFT-1:0] == host_addr[PAGE_SHIFT-1:0]));

   // R10: outputs are quiet without a hit
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !win_hit |-> (card_addr == '0 && !card_we && !card_attr && card_ws == 2'b00));

endmodule

// File: tb/pcmw_mapper_test.sv
module pcmw_mapper_test;

   localparam int NW   = 5;
   localparam int BASE = 16;
   localparam int ENA  = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_idx = 8'h00;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [7:0]  cfg_rdata;
   logic [23:0] host_addr = 24'h0;
   logic        host_wr = 1'b0;
   logic        win_hit;
   logic [2:0]  win_idx;
   logic [25:0] card_addr;
   logic        card_we, card_wide16, card_zero_ws, card_attr;
   logic [1:0]  card_ws;

   int n_run = 0;
   int n_fail = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   pcmw_mapper uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .host_addr(host_addr),
      .host_wr(host_wr), .win_hit(win_hit), .win_idx(win_idx),
      .card_addr(card_addr), .card_we(card_we), .card_wide16(card_wide16),
      .card_zero_ws(card_zero_ws), .card_ws(card_ws), .card_attr(card_attr)
   );

   // behavioural reference: bytes per window, enable bits
   logic [7:0]    mb [NW][6];
   logic [NW-1:0] m_ena;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ena <= '0;
         for (int w = 0; w < NW; w++)
            for (int k = 0; k < 6; k++) mb[w][k] <= 8'h00;
      end else if (cfg_we) begin
         if (int'(cfg_idx) == ENA) m_ena <= cfg_wdata[NW-1:0];
         for (int w = 0; w < NW; w++)
            for (int k = 0; k < 6; k++)
               if (int'(cfg_idx) == BASE + 8*w + k) mb[w][k] <= cfg_wdata;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   // compare on every falling edge, after inputs have settled
   always begin
      @(negedge clk);
      #2;
      begin
         int found;
         int page;
         int st, sp;
         logic [13:0] cpg;
         logic [25:0] e_addr;
         logic [7:0]  e_rd;
         found = -1;
         page = int'(host_addr[23:12]);
         for (int w = NW - 1; w >= 0; w--) begin
            st = int'({mb[w][1][3:0], mb[w][0]});
            sp = int'({mb[w][3][3:0], mb[w][2]});
            if (m_ena[w] && page >= st && page <= sp) found = w;
         end
         if (found >= 0) begin
            cpg = 14'(page + int'({mb[found][5][5:0], mb[found][4]}));
            e_addr = {cpg, host_addr[11:0]};
            chk(win_hit === 1'b1, "R1 hit", 32'(win_hit), 32'd1);
            chk(win_idx === 3'(found), "R7 window select", 32'(win_idx), 32'(found));
            chk(card_addr === e_addr, "R3 translation", 32'(card_addr), 32'(e_addr));
            chk(card_wide16 === mb[found][1][7], "R5 width", 32'(card_wide16), 32'(mb[found][1][7]));
            chk(card_zero_ws === mb[found][1][6], "R5 zero wait", 32'(card_zero_ws), 32'(mb[found][1][6]));
            chk(card_ws === mb[found][3][7:6], "R5 wait select", 32'(card_ws), 32'(mb[found][3][7:6]));
            chk(card_attr === mb[found][5][6], "R6 attribute", 32'(card_attr), 32'(mb[found][5][6]));
            chk(card_we === (host_wr && !mb[found][5][7]), "R6 write protect",
                32'(card_we), 32'(host_wr && !mb[found][5][7]));
         end else begin
            chk(win_hit === 1'b0, "R1 miss", 32'(win_hit), 32'd0);
            chk({win_idx, card_addr, card_we, card_wide16, card_zero_ws, card_ws, card_attr} === '0,
                "R10 idle outputs", 32'(card_addr), 32'd0);
         end
         e_rd = 8'h00;
         if (int'(cfg_idx) == ENA) e_rd = 8'(m_ena);
         for (int w = 0; w < NW; w++)
            for (int k = 0; k < 6; k++)
               if (int'(cfg_idx) == BASE + 8*w + k) e_rd = mb[w][k];
         chk(cfg_rdata === e_rd, "R8 R4 R9 readback", 32'(cfg_rdata), 32'(e_rd));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<50000", cycles);
         summary();
      end
   end

   task automatic wr(input int idx, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 8'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // program window: start, stop, offset with flag bytes
   task automatic prog(input int w, input logic [11:0] st, input logic [1:0] sflg,
                       input logic [11:0] sp, input logic [1:0] ws,
                       input logic [13:0] ofs, input logic [1:0] oflg);
      wr(BASE + 8*w + 0, st[7:0]);
      wr(BASE + 8*w + 1, {sflg, 2'b00, st[11:8]});
      wr(BASE + 8*w + 2, sp[7:0]);
      wr(BASE + 8*w + 3, {ws, 2'b00, sp[11:8]});
      wr(BASE + 8*w + 4, ofs[7:0]);
      wr(BASE + 8*w + 5, {oflg, ofs[13:8]});
   endtask

   task automatic host(input logic [23:0] a, input logic w);
      @(negedge clk);
      host_addr = a; host_wr = w;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state of enable register and window bytes
      cfg_idx = 8'(ENA);
      #1 chk(cfg_rdata === 8'h00, "R2 reset enable", 32'(cfg_rdata), 32'd0);
      rst_n = 1'b1;

      // window 0: pages 0x100..0x10F, offset 0x200, 16-bit
      prog(0, 12'h100, 2'b10, 12'h10F, 2'b01, 14'h0200, 2'b00);
      host(24'h100123, 1'b0);           // R2: not yet enabled
      wr(ENA, 8'h01);
      host(24'h0FFFFF, 1'b0);           // R1 just below
      host(24'h100000, 1'b1);           // R1 first page
      host(24'h10FFFF, 1'b1);           // R1 last page inclusive
      host(24'h110000, 1'b0);           // R1 just above
      // window 1 overlaps, wraps the card page, protected + attribute
      prog(1, 12'h108, 2'b01, 12'h120, 2'b10, 14'h3F00, 2'b11);
      wr(ENA, 8'hE3);                   // R2 upper bits not stored
      host(24'h108ABC, 1'b1);           // R7 window 0 wins
      host(24'h115000, 1'b1);           // R6 protected write, R3 wrap
      // R8: disable window 0 while decoding the overlap in the same cycle
      host(24'h10A555, 1'b1);
      wr(ENA, 8'h02);
      // window 4: single top page with max offset
      prog(4, 12'hFFF, 2'b11, 12'hFFF, 2'b11, 14'h3FFF, 2'b01);
      wr(ENA, 8'h12);
      host(24'hFFF001, 1'b1);
      host(24'hFFEFFF, 1'b0);
      // window 2: stop below start never hits
      prog(2, 12'h500, 2'b00, 12'h4FF, 2'b00, 14'h0001, 2'b00);
      wr(ENA, 8'h16);
      host(24'h500000, 1'b0);
      host(24'h4FF000, 1'b0);
      // R9: unmapped indices
      wr(BASE + 6, 8'hAA);
      wr(BASE + 8*4 + 7, 8'h55);
      wr(7, 8'hFF);
      wr(200, 8'h3C);
      host(24'h110000, 1'b1);
      // R8: rewrite bounds under a held address in the same cycle
      host(24'h130000, 1'b1);
      wr(BASE + 8 + 2, 8'h30);
      wr(BASE + 8 + 4, 8'h00);
      // random register traffic and addresses
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         host_addr = 24'($urandom) & 24'h1FFFFF;
         if ($urandom_range(0, 7) == 0) host_addr[23:12] = 12'hFFF;
         host_wr = 1'($urandom);
         cfg_we = ($urandom_range(0, 3) == 0);
         case ($urandom_range(0, 3))
            0: cfg_idx = 8'(ENA);
            1: cfg_idx = 8'($urandom_range(0, 63));
            default: cfg_idx = 8'(BASE + 8*$urandom_range(0, NW-1) + $urandom_range(0, 5));
         endcase
         cfg_wdata = 8'($urandom);
         if (cfg_we && (cfg_idx[3:0] == 4'h1 || cfg_idx[3:0] == 4'h9 ||
                        cfg_idx[3:0] == 4'h3 || cfg_idx[3:0] == 4'hB))
            cfg_wdata[3:1] = 3'b000;   // keep windows small in random traffic
      end
      @(negedge clk);
      cfg_we = 1'b0;
      repeat (3) @(negedge clk);
      summary();
   end

endmodule